// File: doc/BRIEF.md
# Peripheral Idle Timer and Access Trap Monitor

This block watches I/O bus cycles for one peripheral and compares each cycle address against a programmable inclusive window. It supports the two halves of peripheral power management. While the device is powered, an idle countdown is reloaded by every qualifying access. When the countdown runs out, the device is declared idle. After software has powered the device down, an access trap catches the next access to the window so that software can power the device back up and restart the access.

Each event sets its own sticky status flag. A single SMI request line is the OR of every flag whose SMI enable is set. The block also produces a forward strobe that routes an in-window cycle to the ISA side. Two further sources can reload the countdown, each with its own enable: a DMA-acknowledge activity input and a general-purpose activity input. Cycles tagged as coming from an external PCI-based IDE device are excluded from all power-management effects.

Software programs the window and the reload count first, then enables the features through a control register. The countdown advances only on cycles where the `tick` input is high, so the time base is set outside the block.

Top module: `periph_idle_trap`

## Requirements
- R1: Register writes use `reg_sel`: 0 sets the window low address, 1 the window high address, 2 the reload count, 3 the control word, and 4 clears status. Control bits: 0 window enable, 1 ISA forward enable, 2 idle enable, 3 idle SMI enable, 4 trap enable, 5 trap SMI enable, 6 DMA-ack reload enable, 7 general-purpose reload enable. A written value takes effect from the next clock edge.
- R2: A cycle hits when `cyc_valid` is high, the window enable is set, and low <= `cyc_addr` <= high. Both bounds are inclusive.
- R3: While idle is enabled, each `tick` decrements the count. A non-external hit reloads the count, and the reload wins over a tick in the same cycle.
- R4: The tick edge that takes the count from 1 to 0 sets `sts_idle` at that same edge. The count then rests at 0.
- R5: A `dack_act` or `gpi_act` pulse reloads the count only when its own reload enable bit is set. Otherwise it has no effect.
- R6: A non-external hit with trap enable set causes `sts_trap` to be high after the next edge.
- R7: A cycle with `cyc_ext_ide` high neither reloads the count nor sets `sts_trap`.
- R8: `fwd_isa` is high in the same cycle as a hit when ISA forward enable is set. It ignores `cyc_ext_ide`.
- R9: Status flags reset to 0 and are sticky. Writing 1 to bit 0 (idle) or bit 1 (trap) of status register 4 clears that flag. A set in the same cycle wins over a clear.
- R10: `smi_req` is combinationally high when (`sts_idle` and idle SMI enable) or (`sts_trap` and trap SMI enable).
- R11: A reload count of 0 never produces an expiry.
- R12: Writing control with idle enable = 1 restarts the count from the reload value. Idle enable = 0 freezes the count and suppresses expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_valid | input | 1 | Bus cycle strobe |
| cyc_addr | input | ADDR_W | Decoded cycle address |
| cyc_ext_ide | input | 1 | Cycle originates from external PCI IDE device |
| dack_act | input | 1 | DMA-acknowledge activity pulse |
| gpi_act | input | 1 | General-purpose activity pulse |
| tick | input | 1 | Countdown time-base enable |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | DATA_W | Register write data |
| fwd_isa | output | 1 | Forward current cycle to ISA side |
| sts_idle | output | 1 | Sticky idle-expiry flag |
| sts_trap | output | 1 | Sticky access-trap flag |
| smi_req | output | 1 | Combined SMI request |

## Verification
`fwd_isa` is combinational, so the bench samples it 1 ns after driving a cycle, within that same cycle. Status flags and the SMI request depend on one register stage, so they are sampled at the falling edge after the clock edge that consumed the stimulus. Every stimulus is driven at a falling edge and lasts exactly one clock. Idle checks count tick edges from the restart write: with reload N, the flag must be low after N-1 ticks and high after the Nth tick.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;

  typedef enum logic [2:0] {
    SEL_LOW    = 3'd0,
    SEL_HIGH   = 3'd1,
    SEL_RELOAD = 3'd2,
    SEL_CTRL   = 3'd3,
    SEL_STATUS = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic gpi_rl_en;
    logic dack_rl_en;
    logic trap_smi_en;
    logic trap_en;
    logic idle_smi_en;
    logic idle_en;
    logic fwd_en;
    logic win_en;
  } ctrl_t;

  localparam int CTRL_W       = 8;
  localparam int IDLE_EN_BIT  = 2;
  localparam int NUM_FLAGS    = 2;
  localparam int FLAG_IDLE    = 0;
  localparam int FLAG_TRAP    = 1;

endpackage

// File: rtl/pit_rst_sync.sv
`timescale 1ns/1ps
module pit_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      out_q  <= meta_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/pit_cfg_regs.sv
`timescale 1ns/1ps
module pit_cfg_regs
  import pit_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [2:0]           reg_sel,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [ADDR_W-1:0]    low_q,
  output logic [ADDR_W-1:0]    high_q,
  output logic [CNT_W-1:0]     reload_q,
  output ctrl_t                ctrl_q,
  output logic                 restart,
  output logic [NUM_FLAGS-1:0] clr_mask
);
  logic [ADDR_W-1:0] low_d;
  logic [ADDR_W-1:0] high_d;
  logic [CNT_W-1:0]  reload_d;
  ctrl_t             ctrl_d;
  logic              low_we;
  logic              high_we;
  logic              reload_we;
  logic              ctrl_we;
  logic              sts_we;

  always_comb begin
    low_we    = 1'b0;
    high_we   = 1'b0;
    reload_we = 1'b0;
    ctrl_we   = 1'b0;
    sts_we    = 1'b0;
    if (reg_wr) begin
      case (reg_sel)
        SEL_LOW:    low_we    = 1'b1;
        SEL_HIGH:   high_we   = 1'b1;
        SEL_RELOAD: reload_we = 1'b1;
        SEL_CTRL:   ctrl_we   = 1'b1;
        SEL_STATUS: sts_we    = 1'b1;
        default:    ;
      endcase
    end
  end

  always_comb begin
    low_d    = low_we    ? reg_wdata[ADDR_W-1:0] : low_q;
    high_d   = high_we   ? reg_wdata[ADDR_W-1:0] : high_q;
    reload_d = reload_we ? reg_wdata[CNT_W-1:0]  : reload_q;
    ctrl_d   = ctrl_we   ? ctrl_t'(reg_wdata[CTRL_W-1:0]) : ctrl_q;
  end

  assign restart  = ctrl_we && reg_wdata[IDLE_EN_BIT];
  assign clr_mask = sts_we ? reg_wdata[NUM_FLAGS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q    <= '0;
      high_q   <= '0;
      reload_q <= '0;
      ctrl_q   <= '0;
    end else begin
      low_q    <= low_d;
      high_q   <= high_d;
      reload_q <= reload_d;
      ctrl_q   <= ctrl_d;
    end
  end
endmodule

// File: rtl/pit_range_match.sv
`timescale 1ns/1ps
module pit_range_match #(
  parameter int ADDR_W = 16
) (
  input  logic              cyc_valid,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic              cyc_ext_ide,
  input  logic [ADDR_W-1:0] low,
  input  logic [ADDR_W-1:0] high,
  input  logic              win_en,
  input  logic              fwd_en,
  output logic              pm_hit,
  output logic              fwd
);
  logic above_low;
  logic below_high;
  logic win_hit;

  assign above_low  = (cyc_addr >= low);
  assign below_high = (cyc_addr <= high);
  assign win_hit    = cyc_valid && win_en && above_low && below_high;
  assign pm_hit     = win_hit && !cyc_ext_ide;
  assign fwd        = win_hit && fwd_en;
endmodule

// File: rtl/pit_idle_counter.sv
`timescale 1ns/1ps
module pit_idle_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             restart,
  input  logic             reload_evt,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             may_dec;

  assign may_dec = tick && (reload != '0) && (cnt_q != '0);

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    expire = 1'b0;
    if (restart) begin
      cnt_d  = reload;
      cnt_en = 1'b1;
    end else if (enable) begin
      if (reload_evt) begin
        cnt_d  = reload;
        cnt_en = 1'b1;
      end else if (may_dec) begin
        cnt_d  = cnt_q - 1'b1;
        cnt_en = 1'b1;
        expire = (cnt_q == CNT_W'(1));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/pit_sticky_flags.sv
`timescale 1ns/1ps
module pit_sticky_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic d;
    logic en;
    logic r;

    always_comb begin
      en = set[i] || clr[i];
      d  = set[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r <= 1'b0;
      end else if (en) begin
        r <= d;
      end
    end

    assign q[i] = r;
  end
endmodule

// File: rtl/periph_idle_trap.sv
`timescale 1ns/1ps
module periph_idle_trap
  import pit_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  localparam int DATA_W = (ADDR_W > CNT_W) ?
                          ((ADDR_W > CTRL_W) ? ADDR_W : CTRL_W) :
                          ((CNT_W > CTRL_W) ? CNT_W : CTRL_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_valid,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic              cyc_ext_ide,
  input  logic              dack_act,
  input  logic              gpi_act,
  input  logic              tick,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              fwd_isa,
  output logic              sts_idle,
  output logic              sts_trap,
  output logic              smi_req
);
  logic                 rst_sync_n;
  logic [ADDR_W-1:0]    low_q;
  logic [ADDR_W-1:0]    high_q;
  logic [CNT_W-1:0]     reload_q;
  ctrl_t                ctrl_q;
  logic                 restart;
  logic [NUM_FLAGS-1:0] clr_mask;
  logic                 pm_hit;
  logic                 reload_evt;
  logic [CNT_W-1:0]     cnt_q;
  logic                 expire;
  logic [NUM_FLAGS-1:0] flag_set;
  logic [NUM_FLAGS-1:0] flag_q;
  logic [NUM_FLAGS-1:0] flag_smi_en;

  pit_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pit_cfg_regs #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .low_q     (low_q),
    .high_q    (high_q),
    .reload_q  (reload_q),
    .ctrl_q    (ctrl_q),
    .restart   (restart),
    .clr_mask  (clr_mask)
  );

  pit_range_match #(
    .ADDR_W (ADDR_W)
  ) u_match (
    .cyc_valid   (cyc_valid),
    .cyc_addr    (cyc_addr),
    .cyc_ext_ide (cyc_ext_ide),
    .low         (low_q),
    .high        (high_q),
    .win_en      (ctrl_q.win_en),
    .fwd_en      (ctrl_q.fwd_en),
    .pm_hit      (pm_hit),
    .fwd         (fwd_isa)
  );

  assign reload_evt = pm_hit
                   || (dack_act && ctrl_q.dack_rl_en)
                   || (gpi_act  && ctrl_q.gpi_rl_en);

  pit_idle_counter #(
    .CNT_W (CNT_W)
  ) u_idle (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .enable     (ctrl_q.idle_en),
    .restart    (restart),
    .reload_evt (reload_evt),
    .tick       (tick),
    .reload     (reload_q),
    .cnt_q      (cnt_q),
    .expire     (expire)
  );

  always_comb begin
    flag_set              = '0;
    flag_set[FLAG_IDLE]   = expire;
    flag_set[FLAG_TRAP]   = pm_hit && ctrl_q.trap_en;
    flag_smi_en            = '0;
    flag_smi_en[FLAG_IDLE] = ctrl_q.idle_smi_en;
    flag_smi_en[FLAG_TRAP] = ctrl_q.trap_smi_en;
  end

  pit_sticky_flags #(
    .N (NUM_FLAGS)
  ) u_flags (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set   (flag_set),
    .clr   (clr_mask),
    .q     (flag_q)
  );

  assign sts_idle = flag_q[FLAG_IDLE];
  assign sts_trap = flag_q[FLAG_TRAP];
  assign smi_req  = |(flag_q & flag_smi_en);
endmodule

// File: rtl/pit_checker.sv
`timescale 1ns/1ps
module pit_checker
  import pit_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_valid,
  input logic              cyc_ext_ide,
  input logic              tick,
  input logic              reg_wr,
  input logic [2:0]        reg_sel,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              pm_hit,
  input ctrl_t             ctrl_q,
  input logic [CNT_W-1:0]  reload_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              fwd_isa,
  input logic              sts_idle,
  input logic              sts_trap,
  input logic              smi_req
);
  logic clr_trap_wr;
  assign clr_trap_wr = reg_wr && (reg_sel == SEL_STATUS) && reg_wdata[FLAG_TRAP];

  AST_TRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_hit && ctrl_q.trap_en) |=> sts_trap); // R6

  AST_EXT_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_ext_ide && !sts_trap) |=> !sts_trap); // R7

  AST_TRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_trap && !clr_trap_wr) |=> sts_trap); // R9

  AST_IDLE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_idle) |-> ($past(tick) && $past(ctrl_q.idle_en))); // R4

  AST_ZERO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_q == '0 && !sts_idle && !reg_wr) |=> !sts_idle); // R11

  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.idle_en && !reg_wr) |=> $stable(cnt_q)); // R12

  AST_FWD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_isa |-> (cyc_valid && ctrl_q.win_en && ctrl_q.fwd_en)); // R8

  AST_SMI_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req |-> (sts_idle || sts_trap)); // R10
endmodule

bind periph_idle_trap pit_checker #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .cyc_valid   (cyc_valid),
  .cyc_ext_ide (cyc_ext_ide),
  .tick        (tick),
  .reg_wr      (reg_wr),
  .reg_sel     (reg_sel),
  .reg_wdata   (reg_wdata),
  .pm_hit      (pm_hit),
  .ctrl_q      (ctrl_q),
  .reload_q    (reload_q),
  .cnt_q       (cnt_q),
  .fwd_isa     (fwd_isa),
  .sts_idle    (sts_idle),
  .sts_trap    (sts_trap),
  .smi_req     (smi_req)
);

// File: tb/periph_idle_trap_bench.sv
`timescale 1ns/1ps
module periph_idle_trap_bench;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 16;

  localparam logic [15:0] C_WIN   = 16'h0001;
  localparam logic [15:0] C_FWD   = 16'h0002;
  localparam logic [15:0] C_IDLE  = 16'h0004;
  localparam logic [15:0] C_ISMI  = 16'h0008;
  localparam logic [15:0] C_TRAP  = 16'h0010;
  localparam logic [15:0] C_TSMI  = 16'h0020;
  localparam logic [15:0] C_DACK  = 16'h0040;
  localparam logic [15:0] C_GPI   = 16'h0080;

  logic              clk;
  logic              rst_n;
  logic              cyc_valid;
  logic [ADDR_W-1:0] cyc_addr;
  logic              cyc_ext_ide;
  logic              dack_act;
  logic              gpi_act;
  logic              tick;
  logic              reg_wr;
  logic [2:0]        reg_sel;
  logic [DATA_W-1:0] reg_wdata;
  logic              fwd_isa;
  logic              sts_idle;
  logic              sts_trap;
  logic              smi_req;

  int  vectors;
  int  fails;
  logic fwd_now;
  bit  done;

  periph_idle_trap #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_periph_idle_trap (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_addr(cyc_addr),
    .cyc_ext_ide(cyc_ext_ide), .dack_act(dack_act), .gpi_act(gpi_act),
    .tick(tick), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .fwd_isa(fwd_isa), .sts_idle(sts_idle), .sts_trap(sts_trap), .smi_req(smi_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      summary();
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cyc_valid = 1'b0; cyc_addr = '0; cyc_ext_ide = 1'b0;
    dack_act = 1'b0; gpi_act = 1'b0; tick = 1'b0;
    reg_wr = 1'b0; reg_sel = '0; reg_wdata = '0;
  endtask

  // One clock of stimulus, starting and ending at a falling edge.
  task automatic step(input logic v, input logic [15:0] a, input logic e,
                      input logic d, input logic g, input logic t,
                      input logic w, input logic [2:0] s, input logic [15:0] wd);
    cyc_valid = v; cyc_addr = a; cyc_ext_ide = e;
    dack_act = d; gpi_act = g; tick = t;
    reg_wr = w; reg_sel = s; reg_wdata = wd;
    #1;
    fwd_now = fwd_isa;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] wd);
    step(0, 0, 0, 0, 0, 0, 1, s, wd);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 1, 0, 0, 0);
  endtask

  task automatic cyc(input logic [15:0] a, input logic e);
    step(1, a, e, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic clear_all();
    wr(3'd4, 16'h0003);
  endtask

  initial begin
    vectors = 0; fails = 0; done = 1'b0; fwd_now = 1'b0;
    idle_inputs();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state (R9, R10, R8)
    check("R9 reset sts_idle", sts_idle, 1'b0);
    check("R9 reset sts_trap", sts_trap, 1'b0);
    check("R10 reset smi_req", smi_req, 1'b0);
    check("R8 reset fwd_isa", fwd_isa, 1'b0);

    // Address sweep with window 20..40 (R1, R2, R6, R8, R10, R9)
    wr(3'd0, 16'd20);
    wr(3'd1, 16'd40);
    wr(3'd3, C_WIN | C_FWD | C_TRAP | C_TSMI);
    for (int a = 0; a < 64; a++) begin
      logic inr;
      inr = (a >= 20) && (a <= 40);
      cyc(16'(a), 1'b0);
      check("R2 fwd on window hit", fwd_now, inr);
      check("R6 trap on window hit", sts_trap, inr);
      check("R10 smi from trap", smi_req, inr);
      clear_all();
      check("R9 trap cleared by write-1", sts_trap, 1'b0);
    end

    // External IDE tag: forwarded but no trap (R7, R8)
    for (int a = 16; a < 45; a++) begin
      logic inr;
      inr = (a >= 20) && (a <= 40);
      cyc(16'(a), 1'b1);
      check("R8 fwd ignores ext tag", fwd_now, inr);
      check("R7 ext cycle no trap", sts_trap, 1'b0);
    end

    // Single-address window at 50, boundary (R2, R1)
    wr(3'd0, 16'd50);
    wr(3'd1, 16'd50);
    for (int a = 48; a < 53; a++) begin
      cyc(16'(a), 1'b0);
      check("R2 single-address window", sts_trap, a == 50);
      check("R1 new bounds forward", fwd_now, a == 50);
      clear_all();
    end

    // Trap without SMI enable (R6, R10)
    wr(3'd3, C_WIN | C_TRAP);
    cyc(16'd50, 1'b0);
    check("R6 trap set without smi", sts_trap, 1'b1);
    check("R10 smi masked", smi_req, 1'b0);
    clear_all();

    // Window disabled: no hit (R2)
    wr(3'd3, C_FWD | C_TRAP | C_TSMI);
    cyc(16'd50, 1'b0);
    check("R2 window disabled no fwd", fwd_now, 1'b0);
    check("R2 window disabled no trap", sts_trap, 1'b0);

    // Forward disabled, trap still works (R8)
    wr(3'd3, C_WIN | C_TRAP);
    cyc(16'd50, 1'b0);
    check("R8 forward disabled", fwd_now, 1'b0);
    check("R8 trap independent of forward", sts_trap, 1'b1);
    clear_all();

    // Expiry sweep over reload counts 1..8 (R3, R4, R10)
    for (int n = 1; n <= 8; n++) begin
      wr(3'd2, 16'(n));
      wr(3'd3, C_IDLE | C_ISMI);
      for (int k = 1; k <= n; k++) begin
        ticks(1);
        check("R4 idle expiry on last tick", sts_idle, k == n);
        check("R10 smi from idle", smi_req, k == n);
      end
      ticks(3);
      check("R4 idle stays set", sts_idle, 1'b1);
      clear_all();
      ticks(3);
      check("R4 count rests at zero", sts_idle, 1'b0);
    end

    // Hit reload beats tick (R3); ext hit no reload (R7)
    wr(3'd0, 16'd20);
    wr(3'd1, 16'd40);
    wr(3'd2, 16'd5);
    wr(3'd3, C_WIN | C_IDLE);
    ticks(3);
    step(1, 16'd30, 0, 0, 0, 1, 0, 0, 0);
    ticks(4);
    check("R3 hit reloaded count", sts_idle, 1'b0);
    ticks(1);
    check("R3 expiry after reload", sts_idle, 1'b1);
    check("R10 idle smi disabled", smi_req, 1'b0);
    clear_all();

    wr(3'd3, C_WIN | C_IDLE);
    ticks(3);
    cyc(16'd30, 1'b1);
    ticks(1);
    check("R7 ext hit did not reload", sts_idle, 1'b0);
    ticks(1);
    check("R7 ext hit did not reload", sts_idle, 1'b1);
    clear_all();

    // DMA-ack and GP reload gating (R5)
    wr(3'd3, C_IDLE);
    ticks(3);
    step(0, 0, 0, 1, 1, 0, 0, 0, 0);
    ticks(2);
    check("R5 disabled activity ignored", sts_idle, 1'b1);
    clear_all();

    wr(3'd3, C_IDLE | C_DACK);
    ticks(3);
    step(0, 0, 0, 1, 0, 0, 0, 0, 0);
    ticks(4);
    check("R5 dack reload", sts_idle, 1'b0);
    ticks(1);
    check("R5 dack reload expiry", sts_idle, 1'b1);
    clear_all();

    wr(3'd3, C_IDLE | C_GPI);
    ticks(3);
    step(0, 0, 0, 0, 1, 0, 0, 0, 0);
    ticks(4);
    check("R5 gpi reload", sts_idle, 1'b0);
    ticks(1);
    check("R5 gpi reload expiry", sts_idle, 1'b1);
    clear_all();

    // Zero reload never expires (R11)
    wr(3'd2, 16'd0);
    wr(3'd3, C_IDLE | C_ISMI);
    ticks(20);
    check("R11 zero reload no expiry", sts_idle, 1'b0);

    // Freeze and restart (R12)
    wr(3'd2, 16'd4);
    wr(3'd3, C_IDLE);
    ticks(2);
    wr(3'd3, 16'h0000);
    ticks(10);
    check("R12 disabled timer frozen", sts_idle, 1'b0);
    wr(3'd3, C_IDLE);
    ticks(3);
    check("R12 restart from reload", sts_idle, 1'b0);
    ticks(1);
    check("R12 restart expiry", sts_idle, 1'b1);

    // Selective clear and set-over-clear (R9)
    wr(3'd3, C_WIN | C_TRAP | C_TSMI);
    cyc(16'd25, 1'b0);
    wr(3'd4, 16'h0002);
    check("R9 trap cleared alone", sts_trap, 1'b0);
    check("R9 idle unaffected by trap clear", sts_idle, 1'b1);
    step(1, 16'd25, 0, 0, 0, 0, 1, 3'd4, 16'h0002);
    check("R9 set wins over clear", sts_trap, 1'b1);
    clear_all();
    check("R9 both cleared", sts_trap | sts_idle, 1'b0);

    done = 1'b1;
    summary();
  end
endmodule